// File: doc/BRIEF.md
# UART Interrupt Enable and Status Controller

This block gathers the event pulses of a UART (from its FIFOs, receiver, transmitter and modem-line logic) into a sticky status register. It gates that register with a mask to produce one level-sensitive interrupt line. Each of the fourteen event sources owns one bit position. The position is the same in every register of the block.

Software reaches the block through a simple 32-bit register port. Writes take effect at the next rising clock edge. Reads are combinational from the current address. Four word addresses are decoded:

| Word | Byte offset | Function |
|------|-------------|----------|
| 0 | 0x0 | Enable (write-1-to-set of the mask) |
| 1 | 0x4 | Disable (write-1-to-clear of the mask) |
| 2 | 0x8 | Mask, read-only |
| 3 | 0xC | Status, read, and write-1-to-clear |

The mask therefore never takes a whole new value from one write. Two masters sharing the line can enable or disable their own sources without a read-modify-write race.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, the mask and the status both read 0 and `irq_o` is low.
- R2: A write to byte offset 0x0 sets every mask bit whose `reg_wdata` bit is 1, from the next edge on. Mask bits written with 0 keep their value.
- R3: A write to byte offset 0x4 clears every mask bit whose `reg_wdata` bit is 1. Mask bits written with 0 keep their value.
- R4: Reads at offsets 0x0 and 0x4 always return 0.
- R5: The mask changes only through writes at 0x0 or 0x4. A write at 0x8 changes neither the mask nor the status.
- R6: A 1 on `evt_i[k]` at a clock edge sets status bit k at that edge, whatever the mask holds. The bit stays set without further pulses.
- R7: A write at 0xC clears every status bit whose `reg_wdata` bit is 1. Status bits written with 0 keep their value.
- R8: When an event pulse and a status clear of the same bit meet at one edge, the bit is set after that edge.
- R9: `irq_o` is 1 exactly when some bit is set in both the status and the mask.
- R10: Bit positions from bit 0 are: RX FIFO trigger, RX FIFO empty, RX FIFO full, TX FIFO empty, TX FIFO full, RX overrun, framing error, parity error, RX timeout, modem status change, TX FIFO trigger, TX FIFO nearly full, TX FIFO overflow, RX break. `evt_i` uses the same order.
- R11: Bits 31:14 read as 0 at every offset, and their write values have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 14 | Single-cycle event pulses, one per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bound checker watches these behaviours on every cycle:
- an event always leaves its status bit set, including when a clear hits the same bit;
- a status bit falls only under a matching write-1 clear;
- mask bits move only as the enable and disable writes direct;
- the enable and disable addresses read zero;
- the interrupt is never raised with an empty mask or an empty status.

The bench's scenarios show the rest:
- the exact reset values;
- the per-source bit order;
- that write-0 bits and writes to the read-only mask word have no effect;
- that `irq_o` follows the masked status exactly, including staying low while a status bit waits behind a cleared mask.

// File: rtl/uart_irq_pkg.sv
// Package: uart_irq_pkg
// Shared constants and types for the UART interrupt controller.
// Assumes a 32-bit register port and word-aligned register offsets.
package uart_irq_pkg;

    localparam int NUM_SRC  = 14;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int WORD_LSB = 2;

    // Register word index, decoded from reg_addr[3:2]
    typedef enum logic [1:0] {
        REG_ENABLE  = 2'd0,
        REG_DISABLE = 2'd1,
        REG_MASK    = 2'd2,
        REG_STATUS  = 2'd3
    } reg_word_e;

    // Event sources; the member order fixes the bit positions (MSB first)
    typedef struct packed {
        logic rx_break;
        logic tx_overflow;
        logic tx_near_full;
        logic tx_trigger;
        logic modem_change;
        logic rx_timeout;
        logic parity_err;
        logic framing_err;
        logic rx_overrun;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
        logic rx_trigger;
    } irq_vec_t;

endpackage

// File: rtl/uart_irq_regdec.sv
// Module: uart_irq_regdec
// Decodes the register-port write into per-bit action vectors:
// mask set, mask clear and status clear.
// Assumes byte addressing with the word index in addr[WORD_LSB+1:WORD_LSB].
// Data bits at and above NUM_SRC are dropped here.
module uart_irq_regdec
    import uart_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output reg_word_e        word_sel,
    output logic [N_SRC-1:0] mask_set,
    output logic [N_SRC-1:0] mask_clr,
    output logic [N_SRC-1:0] stat_clr
);

    logic [N_SRC-1:0] wbits;
    logic             unused_bits;

    assign wbits       = reg_wdata[N_SRC-1:0];
    assign unused_bits = ^{reg_wdata[DW-1:N_SRC], reg_addr[WORD_LSB-1:0]};

    // Extract the word index from the byte address
    always_comb begin
        word_sel = reg_word_e'(reg_addr[WORD_LSB +: 2]);
    end

    // Route write data to the action selected by the word index
    always_comb begin
        mask_set = '0;
        mask_clr = '0;
        stat_clr = '0;
        if (reg_wr) begin
            unique case (word_sel)
                REG_ENABLE:  mask_set = wbits;
                REG_DISABLE: mask_clr = wbits;
                REG_STATUS:  stat_clr = wbits;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/uart_irq_mask.sv
// Module: uart_irq_mask
// Holds the interrupt mask. Bits are changed only by the set and clear
// vectors. Assumes set and clear never name the same bit in one cycle,
// since they come from different word addresses of one write port.
module uart_irq_mask #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] mask_set,
    input  logic [N_SRC-1:0] mask_clr,
    output logic [N_SRC-1:0] mask_q
);

    // Register the mask with synchronous reset to all-disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | mask_set) & ~mask_clr;
        end
    end

endmodule

// File: rtl/uart_irq_status.sv
// Module: uart_irq_status
// Sticky per-source status bits. An event pulse sets its bit. A
// write-1-to-clear resets the bit, unless an event arrives in the same
// cycle, in which case the event wins. Assumes event pulses are already
// synchronous to clk.
module uart_irq_status #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] status_q
);

    for (genvar k = 0; k < N_SRC; k++) begin : g_bit
        // One sticky flop per source, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[k] <= 1'b0;
            end else if (evt[k]) begin
                status_q[k] <= 1'b1;
            end else if (clr[k]) begin
                status_q[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: uart_irq_ctrl (top)
// UART interrupt enable, mask and sticky status, with a 32-bit register
// port and one level interrupt output. Reads are combinational from
// reg_addr. Unused upper data bits read as zero.
// Assumes reg_addr is stable while reg_rdata is sampled.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_o
);

    reg_word_e        word_sel;
    logic [N_SRC-1:0] mask_set;
    logic [N_SRC-1:0] mask_clr;
    logic [N_SRC-1:0] stat_clr;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] status_q;

    uart_irq_regdec #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .word_sel  (word_sel),
        .mask_set  (mask_set),
        .mask_clr  (mask_clr),
        .stat_clr  (stat_clr)
    );

    uart_irq_mask #(.N_SRC(N_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .mask_q   (mask_q)
    );

    uart_irq_status #(.N_SRC(N_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr      (stat_clr),
        .status_q (status_q)
    );

    // Select read data: mask and status readable, enable/disable read zero
    always_comb begin
        reg_rdata = '0;
        unique case (word_sel)
            REG_MASK:   reg_rdata[N_SRC-1:0] = mask_q;
            REG_STATUS: reg_rdata[N_SRC-1:0] = status_q;
            default:    reg_rdata = '0;
        endcase
    end

    // Combine masked status into the single interrupt line
    always_comb begin
        irq_o = |(status_q & mask_q);
    end

endmodule

// File: rtl/uart_irq_chk.sv
// Module: uart_irq_chk
// Cycle-by-cycle properties of uart_irq_ctrl, attached with bind.
module uart_irq_chk #(
    parameter int N_SRC = 14,
    parameter int DW    = 32,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] evt_i,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [DW-1:0]    reg_rdata,
    input logic             irq_o,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] status_q
);

    logic [1:0]       word;
    logic             wr_en_reg;
    logic             wr_dis_reg;
    logic             wr_stat_reg;
    logic [N_SRC-1:0] wbits;
    logic             unused_chk;

    assign word        = reg_addr[3:2];
    assign wr_en_reg   = reg_wr && (word == 2'd0);
    assign wr_dis_reg  = reg_wr && (word == 2'd1);
    assign wr_stat_reg = reg_wr && (word == 2'd3);
    assign wbits       = reg_wdata[N_SRC-1:0];
    assign unused_chk  = ^{reg_wdata[DW-1:N_SRC], reg_addr[1:0]};

    // R2: enabled bits are set after the write
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_reg |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R3: disabled bits are clear after the write
    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis_reg |=> ((mask_q & $past(wbits)) == '0));

    // R4: enable and disable words read zero
    assert_rd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word == 2'd0 || word == 2'd1) |-> (reg_rdata == '0));

    // R5: mask holds when neither enable nor disable is written
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_reg || wr_dis_reg) |=> $stable(mask_q));

    // R6 and R8: an event always leaves its status bit set
    assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R7: status bits fall only under a matching write-1 clear
    assert_stat_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_reg |=> (($past(status_q) & ~status_q) == '0));

    // R9: interrupt only with a non-empty mask and status
    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '0 && status_q != '0));

    // R11: upper read data bits are always zero
    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:N_SRC] == '0);

endmodule

bind uart_irq_ctrl uart_irq_chk #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench: uart_irq_ctrl_test
// Directed corner cases followed by seeded random traffic, compared
// against a bench-side model of mask and status.
module uart_irq_ctrl_test;

    localparam int NS = 14;
    localparam logic [3:0] A_EN  = 4'h0;
    localparam logic [3:0] A_DIS = 4'h4;
    localparam logic [3:0] A_MSK = 4'h8;
    localparam logic [3:0] A_STA = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt_i = '0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o;

    int errors = 0;
    int checks = 0;
    logic [NS-1:0] m_mask = '0;
    logic [NS-1:0] m_stat = '0;

    always #10 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [NS-1:0] next_mask(logic [NS-1:0] m, logic wr,
                                                logic [3:0] a, logic [31:0] d);
        if (wr && a[3:2] == 2'd0) return m | d[NS-1:0];
        if (wr && a[3:2] == 2'd1) return m & ~d[NS-1:0];
        return m;
    endfunction

    function automatic logic [NS-1:0] next_stat(logic [NS-1:0] s, logic [NS-1:0] e,
                                                logic wr, logic [3:0] a, logic [31:0] d);
        logic [NS-1:0] c;
        c = (wr && a[3:2] == 2'd3) ? d[NS-1:0] : '0;
        return (s & ~c) | e;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock with the given stimulus; model updated after the edge
    task automatic step(logic [NS-1:0] e, logic wr, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        evt_i = e; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        m_mask = next_mask(m_mask, wr, a, d);
        m_stat = next_stat(m_stat, e, wr, a, d);
    endtask

    // Quiet the inputs and compare all readable state at mid-cycle
    task automatic check_all(string tag);
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0;
        reg_addr = A_MSK; #1;
        check({tag, " R2/R3/R5 mask"}, reg_rdata, {18'd0, m_mask});
        reg_addr = A_STA; #1;
        check({tag, " R6/R7 status"}, reg_rdata, {18'd0, m_stat});
        check({tag, " R9 irq"}, {31'd0, irq_o}, {31'd0, |(m_mask & m_stat)});
        reg_addr = A_EN; #1;
        check({tag, " R4 enable reads 0"}, reg_rdata, 32'd0);
        reg_addr = A_DIS; #1;
        check({tag, " R4 disable reads 0"}, reg_rdata, 32'd0);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: enable sets, zeros keep
        step('0, 1'b1, A_EN, 32'h0000_0005);
        step('0, 1'b1, A_EN, 32'h0000_0002);
        check_all("R2 enable");
        // R3: disable clears only written ones
        step('0, 1'b1, A_DIS, 32'h0000_0001);
        check_all("R3 disable");
        // R5: write to mask word ignored; R11: upper bits ignored
        step('0, 1'b1, A_MSK, 32'hFFFF_FFFF);
        step('0, 1'b1, A_EN, 32'hFFFF_C000);
        check_all("R5/R11 ignored");
        // R6: event on masked-off bit 12 sets status, irq stays low
        step(14'h1000, 1'b0, A_EN, 32'd0);
        check_all("R6 sticky masked");
        // R9: enabling bit 12 raises irq
        step('0, 1'b1, A_EN, 32'h0000_1000);
        check_all("R9 irq raise");
        // R7: zero write keeps, one write clears
        step('0, 1'b1, A_STA, 32'h0000_0000);
        check_all("R7 zero write");
        step('0, 1'b1, A_STA, 32'h0000_1000);
        check_all("R7 clear");
        // R8: event and clear on the same edge
        step(14'h0200, 1'b0, A_EN, 32'd0);
        step(14'h0200, 1'b1, A_STA, 32'h0000_0200);
        check_all("R8 event wins");
        step('0, 1'b1, A_STA, 32'h0000_3FFF);
        // R10: each source lands on its own bit
        for (int k = 0; k < NS; k++) begin
            step(NS'(1) << k, 1'b0, A_EN, 32'd0);
            @(negedge clk);
            evt_i = '0; reg_addr = A_STA; #1;
            check($sformatf("R10 source %0d position", k), reg_rdata, 32'd1 << k);
            step('0, 1'b1, A_STA, 32'd1 << k);
        end

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            logic [NS-1:0] e;
            logic [3:0] a;
            e = NS'($urandom & $urandom & $urandom);
            a = {2'($urandom), 2'($urandom)};
            step(e, 1'($urandom), a, $urandom);
            check_all("random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule